// File: doc/BRIEF.md
# PD Port Controller Transmit and Alert Registers

This block sits inside a USB Power Delivery port controller, between a host-side policy manager and the transmitter in the physical layer. The host works through a byte-wide register port. It loads a message header and up to 128 data bytes into a transmit buffer, sets the byte count, and then writes a transmit command. The command carries the SOP* type and a retry limit. The block then pulses a start strobe to the transmitter. The transmitter reads the buffer through its own read port.

Each attempt ends with a done strobe and a result code. A missing response is retried by the block until the retry limit is used up. The final outcome is latched as exactly one of three alert flags: success, failure, or discard. Receive events from the PHY set two further alert flags at any time. All flags share one write-one-to-clear register. After masking, the flags drive an active-low interrupt pin.

A new transmit command is accepted only when the block is idle and every outcome flag has been cleared. While a transmission is in flight, the buffer and the byte count are frozen.

Top module: `pd_tx_alert_regs`

## Requirements
- R1: A byte written at address 0x52+i (i below BUF_DEPTH, default 130) is read back at that address and on `phy_rd_data` for `phy_rd_idx`=i. The count written at 0x51 appears on `phy_byte_count`, clamped to BUF_DEPTH.
- R2: A write to 0x50 that is accepted raises `phy_start` for exactly one cycle, in the cycle after the write. `phy_sop` then presents command bits [2:0].
- R3: `phy_result` 0 sets alert bit 0 (success) and `phy_result` 2 sets alert bit 2 (discarded, never retried). Each transmission sets exactly one of alert bits 0 to 2.
- R4: `alert_n` is low exactly when some alert bit is set whose bit in the 16-bit mask at 0x12/0x13 is 1. After reset the mask is 0xFFFF, the alert register is 0 and `alert_n` is high.
- R5: Writing 1 to a bit of the alert register at 0x10 clears that bit, and writing 0 leaves it unchanged. Address 0x11 and alert bits 7:5 read 0.
- R6: A transmit write is ignored, with no `phy_start` and no change to 0x50, while a transmission is busy or while any of alert bits 0 to 2 is set.
- R7: `phy_result` 1 or 3 means no response. The block then re-pulses `phy_start` in the next cycle, up to the retry limit in command bits [5:4]. When the last attempt also gets no response, alert bit 1 (failed) is set.
- R8: `rx_msg` sets alert bit 3 and `rx_hard_reset` sets alert bit 4, in any state, one cycle after the strobe. A set in the same cycle as a clear of that bit wins.
- R9: Writes to the buffer and to 0x51 are ignored while a transmission is busy.
- R10: Address 0x50 reads back the last accepted transmit command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| phy_start | output | 1 | One-cycle start strobe for each transmit attempt |
| phy_sop | output | 3 | SOP* type of the current command |
| phy_byte_count | output | 8 | Number of buffered bytes to send |
| phy_rd_idx | input | clog2(BUF_DEPTH) | Transmitter buffer read index |
| phy_rd_data | output | 8 | Buffer byte at phy_rd_idx |
| phy_done | input | 1 | Attempt finished strobe |
| phy_result | input | 2 | Attempt result: 0 ok, 2 discarded, 1/3 no response |
| rx_msg | input | 1 | Message received strobe |
| rx_hard_reset | input | 1 | Hard reset received strobe |
| alert_n | output | 1 | Active-low interrupt |

## Verification
A host clear of an alert bit can land in the same cycle as a receive strobe that sets the same bit. Likewise, a receive event can arrive while a transmission is outstanding and resolve in the cycle just before its outcome. The bench provokes the first case by driving a write of 1 to bit 3 at 0x10 together with `rx_msg` in one cycle, and expects bit 3 to stay set. It provokes the second by pulsing `rx_msg` mid-transmission, and expects both the receive flag and the success flag in the register. A behavioural model compares `alert_n` and `phy_start` against the design on every clock throughout.

// File: rtl/pd_tx_alert_regs.sv
`timescale 1ns/1ps
module pd_tx_alert_regs #(
  parameter int BUF_DEPTH = 130,
  parameter int ADDR_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [7:0]                   reg_wdata,
  output logic [7:0]                   reg_rdata,
  output logic                         phy_start,
  output logic [2:0]                   phy_sop,
  output logic [7:0]                   phy_byte_count,
  input  logic [$clog2(BUF_DEPTH)-1:0] phy_rd_idx,
  output logic [7:0]                   phy_rd_data,
  input  logic                         phy_done,
  input  logic [1:0]                   phy_result,
  input  logic                         rx_msg,
  input  logic                         rx_hard_reset,
  output logic                         alert_n
);
  localparam int IDX_W = $clog2(BUF_DEPTH);
  localparam logic [ADDR_W-1:0] A_ALERT_LO = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_MASK_LO  = ADDR_W'('h12);
  localparam logic [ADDR_W-1:0] A_MASK_HI  = ADDR_W'('h13);
  localparam logic [ADDR_W-1:0] A_TX       = ADDR_W'('h50);
  localparam logic [ADDR_W-1:0] A_COUNT    = ADDR_W'('h51);
  localparam logic [ADDR_W-1:0] A_BUF      = ADDR_W'('h52);
  localparam logic [1:0] RES_OK   = 2'd0;
  localparam logic [1:0] RES_DISC = 2'd2;

  logic [7:0]        buf_mem [BUF_DEPTH];
  logic [4:0]        alert_q;
  logic [15:0]       mask_q;
  logic [7:0]        tx_cmd_q;
  logic [7:0]        count_q;
  logic [1:0]        tries;
  logic              busy;
  logic              start_q;

  logic [ADDR_W-1:0] buf_off;
  logic              in_buf;
  logic              wr_tx, pending, accept, done;
  logic              set_ok, set_fail, set_disc, noresp, retry;
  logic [4:0]        set_vec, clr_vec;

  assign buf_off  = reg_addr - A_BUF;
  assign in_buf   = (reg_addr >= A_BUF) && (int'(buf_off) < BUF_DEPTH);
  assign wr_tx    = reg_wr && (reg_addr == A_TX);
  assign pending  = |alert_q[2:0];
  assign accept   = wr_tx && !busy && !pending;
  assign done     = busy && phy_done && !start_q;
  assign set_ok   = done && (phy_result == RES_OK);
  assign set_disc = done && (phy_result == RES_DISC);
  assign noresp   = done && phy_result[0];
  assign retry    = noresp && (tries != 2'd0);
  assign set_fail = noresp && (tries == 2'd0);
  assign set_vec  = {rx_hard_reset, rx_msg, set_disc, set_fail, set_ok};
  assign clr_vec  = (reg_wr && reg_addr == A_ALERT_LO) ? reg_wdata[4:0] : 5'd0;

  always_ff @(posedge clk) begin
    if (reg_wr && in_buf && !busy)
      buf_mem[buf_off[IDX_W-1:0]] <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alert_q  <= '0;
      mask_q   <= 16'hFFFF;
      tx_cmd_q <= '0;
      count_q  <= '0;
      tries    <= '0;
      busy     <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      alert_q <= (alert_q & ~clr_vec) | set_vec;
      start_q <= accept | retry;
      if (reg_wr && reg_addr == A_MASK_LO) mask_q[7:0]  <= reg_wdata;
      if (reg_wr && reg_addr == A_MASK_HI) mask_q[15:8] <= reg_wdata;
      if (reg_wr && reg_addr == A_COUNT && !busy)
        count_q <= (int'(reg_wdata) > BUF_DEPTH) ? 8'(BUF_DEPTH) : reg_wdata;
      if (accept) begin
        tx_cmd_q <= reg_wdata;
        tries    <= reg_wdata[5:4];
        busy     <= 1'b1;
      end else if (retry) begin
        tries    <= tries - 2'd1;
      end else if (set_ok || set_fail || set_disc) begin
        busy     <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (in_buf) reg_rdata = buf_mem[buf_off[IDX_W-1:0]];
    else begin
      case (reg_addr)
        A_ALERT_LO: reg_rdata = {3'b000, alert_q};
        A_MASK_LO:  reg_rdata = mask_q[7:0];
        A_MASK_HI:  reg_rdata = mask_q[15:8];
        A_TX:       reg_rdata = tx_cmd_q;
        A_COUNT:    reg_rdata = count_q;
        default:    reg_rdata = 8'h00;
      endcase
    end
  end

  assign phy_rd_data    = (int'(phy_rd_idx) < BUF_DEPTH) ? buf_mem[phy_rd_idx] : 8'h00;
  assign phy_start      = start_q;
  assign phy_sop        = tx_cmd_q[2:0];
  assign phy_byte_count = count_q;
  assign alert_n        = ~|(alert_q & mask_q[4:0]);

  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phy_start |=> !phy_start);
  p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(alert_q[2:0]) <= 1);
  p_pin_on_success_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(alert_q[0]) && mask_q[0]) |-> !alert_n);
  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_ALERT_LO && reg_wdata[0] && !set_ok) |=> !alert_q[0]);
  p_cmd_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && (busy || pending) && !retry) |=> !phy_start);
  p_fail_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_q[1]) |-> !busy);
  p_rx_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_msg |=> alert_q[3]);
  p_hard_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hard_reset |=> alert_q[4]);
endmodule

// File: tb/test_pd_tx_alert_regs.sv
`timescale 1ns/1ps
module test_pd_tx_alert_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       phy_start;
  logic [2:0] phy_sop;
  logic [7:0] phy_byte_count;
  logic [7:0] phy_rd_idx = 8'h00;
  logic [7:0] phy_rd_data;
  logic       phy_done = 1'b0;
  logic [1:0] phy_result = 2'd0;
  logic       rx_msg = 1'b0;
  logic       rx_hard_reset = 1'b0;
  logic       alert_n;

  int nchk = 0, nerr = 0, n_start = 0;

  always #2.5 clk = ~clk;

  pd_tx_alert_regs i_pd_tx_alert_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .phy_start(phy_start),
    .phy_sop(phy_sop), .phy_byte_count(phy_byte_count), .phy_rd_idx(phy_rd_idx),
    .phy_rd_data(phy_rd_data), .phy_done(phy_done), .phy_result(phy_result),
    .rx_msg(rx_msg), .rx_hard_reset(rx_hard_reset), .alert_n(alert_n));

  logic [4:0]  m_alert;
  logic [15:0] m_mask;
  logic        m_busy, m_start;
  int          m_tries;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_alert = '0; m_mask = 16'hFFFF; m_busy = 0; m_start = 0; m_tries = 0;
    end else begin
      logic b, st;
      logic [4:0] s, c;
      b = m_busy; s = '0; c = '0; st = 0;
      if (b && phy_done && !m_start) begin
        if (phy_result == 2'd0) begin s[0] = 1; m_busy = 0; end
        else if (phy_result == 2'd2) begin s[2] = 1; m_busy = 0; end
        else if (m_tries > 0) begin m_tries--; st = 1; end
        else begin s[1] = 1; m_busy = 0; end
      end
      if (rx_msg) s[3] = 1;
      if (rx_hard_reset) s[4] = 1;
      if (reg_wr) begin
        case (reg_addr)
          8'h10: c = reg_wdata[4:0];
          8'h12: m_mask[7:0] = reg_wdata;
          8'h13: m_mask[15:8] = reg_wdata;
          8'h50: if (!b && m_alert[2:0] == 3'b000) begin
                   m_busy = 1; m_tries = int'(reg_wdata[5:4]); st = 1;
                 end
          default: ;
        endcase
      end
      m_alert = (m_alert & ~c) | s;
      m_start = st;
    end
  end

  always @(posedge clk) if (rst_n && phy_start) n_start++;

  always @(negedge clk) begin
    if (rst_n) begin
      nchk += 2;
      if (alert_n !== ~|(m_alert & m_mask[4:0])) begin
        nerr++;
        $display("FAIL R4 alert_n actual=%b expected=%b", alert_n, ~|(m_alert & m_mask[4:0]));
      end
      if (phy_start !== m_start) begin
        nerr++;
        $display("FAIL R2 phy_start actual=%b expected=%b", phy_start, m_start);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); #0.5;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #0.5;
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); #0.5;
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_start();
    int n = 0;
    while (!phy_start && n < 50) begin
      @(negedge clk); #0.5;
      n++;
    end
    if (!phy_start) chk("R2 start never seen", 0, 1);
  endtask

  task automatic finish_tx(input logic [1:0] res);
    repeat (2) @(negedge clk);
    #0.5 phy_done = 1; phy_result = res;
    @(negedge clk); #0.5 phy_done = 0;
  endtask

  task automatic reply(input logic [1:0] res);
    wait_start();
    finish_tx(res);
  endtask

  task automatic pulse_rx(input logic hard);
    @(negedge clk); #0.5;
    if (hard) rx_hard_reset = 1; else rx_msg = 1;
    @(negedge clk); #0.5;
    rx_hard_reset = 0; rx_msg = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog (R2 handshake) actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n0;
    repeat (4) @(negedge clk);
    #0.5 rst_n = 1;

    rd(8'h10, v); chk("R4 reset alert", v, 8'h00);
    rd(8'h12, v); chk("R4 reset mask lo", v, 8'hFF);
    rd(8'h13, v); chk("R4 reset mask hi", v, 8'hFF);
    chk("R4 reset alert_n", alert_n, 1);

    wr(8'h51, 8'd5);
    for (int i = 0; i < 5; i++) wr(8'h52 + 8'(i), 8'hA0 + 8'(i));
    rd(8'h54, v); chk("R1 buffer read host", v, 8'hA2);
    phy_rd_idx = 8'd4; #0.5 chk("R1 buffer read phy", phy_rd_data, 8'hA4);
    chk("R1 byte count", phy_byte_count, 8'd5);
    wr(8'hD3, 8'h5C); rd(8'hD3, v); chk("R1 last buffer slot", v, 8'h5C);
    wr(8'h51, 8'd200); chk("R1 count clamp", phy_byte_count, 8'd130);
    wr(8'h51, 8'd5);

    n0 = n_start;
    wr(8'h50, 8'h01);
    chk("R2 sop type", phy_sop, 3'd1);
    reply(2'd0);
    rd(8'h10, v); chk("R3 success flag", v, 8'h01);
    chk("R4 alert_n low", alert_n, 0);
    rd(8'h50, v); chk("R10 command readback", v, 8'h01);
    chk("R2 one start", n_start - n0, 1);

    n0 = n_start;
    wr(8'h50, 8'h02);
    repeat (5) @(negedge clk);
    chk("R6 pending blocks start", n_start - n0, 0);
    rd(8'h50, v); chk("R6 R10 command unchanged", v, 8'h01);

    wr(8'h10, 8'h00); rd(8'h10, v); chk("R5 write zero keeps", v, 8'h01);
    wr(8'h10, 8'h01); rd(8'h10, v); chk("R5 write one clears", v, 8'h00);
    chk("R5 alert_n released", alert_n, 1);

    n0 = n_start;
    wr(8'h50, 8'h20);
    reply(2'd1); reply(2'd3); reply(2'd0);
    chk("R7 retries then success starts", n_start - n0, 3);
    rd(8'h10, v); chk("R7 success after retries", v, 8'h01);
    wr(8'h10, 8'h01);

    n0 = n_start;
    wr(8'h50, 8'h10);
    reply(2'd1); reply(2'd1);
    chk("R7 starts before fail", n_start - n0, 2);
    rd(8'h10, v); chk("R7 failed flag", v, 8'h02);
    wr(8'h10, 8'h02);

    n0 = n_start;
    wr(8'h50, 8'h30);
    reply(2'd2);
    repeat (5) @(negedge clk);
    chk("R3 discard no retry", n_start - n0, 1);
    rd(8'h10, v); chk("R3 discarded flag", v, 8'h04);
    wr(8'h10, 8'h04);

    n0 = n_start;
    wr(8'h50, 8'h00);
    wait_start();
    wr(8'h50, 8'h07);
    rd(8'h50, v); chk("R6 busy ignores command", v, 8'h00);
    wr(8'h52, 8'hEE); rd(8'h52, v); chk("R9 buffer frozen", v, 8'hA0);
    wr(8'h51, 8'd9); chk("R9 count frozen", phy_byte_count, 8'd5);
    pulse_rx(1'b0);
    rd(8'h10, v); chk("R8 rx during busy", v, 8'h08);
    finish_tx(2'd0);
    rd(8'h10, v); chk("R3 R8 outcome with rx", v, 8'h09);
    chk("R6 single start while busy", n_start - n0, 1);
    wr(8'h10, 8'h01);

    @(negedge clk); #0.5;
    reg_wr = 1; reg_addr = 8'h10; reg_wdata = 8'h08; rx_msg = 1;
    @(negedge clk); #0.5;
    reg_wr = 0; rx_msg = 0;
    rd(8'h10, v); chk("R8 set wins over clear", v, 8'h08);
    pulse_rx(1'b1);
    rd(8'h10, v); chk("R8 hard reset flag", v, 8'h18);
    wr(8'h10, 8'h1F); rd(8'h10, v); chk("R5 clear all", v, 8'h00);

    wr(8'h12, 8'hF7);
    pulse_rx(1'b0);
    rd(8'h10, v); chk("R4 masked flag visible", v, 8'h08);
    chk("R4 masked pin high", alert_n, 1);
    wr(8'h12, 8'hFF);
    chk("R4 unmask drives pin", alert_n, 0);
    wr(8'h10, 8'h08);

    wr(8'h11, 8'hFF); rd(8'h11, v); chk("R5 upper alert byte zero", v, 8'h00);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule